// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

A register-mapped timer with a parameterised number of channels (two by default). Each channel has its own control word, a 64-bit interval and a readable live count. While enabled, the channel counts down once per prescaled tick.

When a channel expires it either reloads its interval and keeps running (periodic) or parks at zero and drops its own enable bit (one-shot). An expiry sets that channel's pending flag. A mask register picks which pending flags reach the single interrupt line.

Software drives the block over a single-cycle bus: the address and write strobe are sampled on the rising clock edge, and read data is a combinational function of the address. To program a channel, software first disables it and waits for the enable synchroniser to drain. It then writes the interval, and finally writes enable, reload and the mode bit in one access. With an all-ones interval in periodic mode, a channel acts as a free-running source whose bitwise-inverted count rises.

Top module: `evtimer_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Address map. The mask register is at 0x00 and the pending register at 0x04. Channel n has its base at 0x10 + 0x20·n, with control at +0x0, interval low at +0x4, interval high at +0x8, count low at +0xC and count high at +0x10. The interval words read back what was written. Any other address reads zero.
- R3: Control word layout: bit 0 is enable, bit 1 is reload, bits 6:4 are the prescaler select, bit 7 is one-shot, and bits 3:2 read zero. A reload bit written as 1 still reads 1 on the next read. It copies the interval into the count at the following edge and reads 0 after that.
- R4: On each tick that the synchronised enable accepts, a nonzero count drops by one. A tick that finds the count at zero while the enable bit is set is an expiry. After a control write at edge W with prescaler select 0, the count first moves at edge W+3 and the first expiry is at edge W+3+interval.
- R5: In periodic mode (bit 7 clear) an expiry reloads the interval, so later expiries come every interval+1 ticks.
- R6: In one-shot mode an expiry leaves the count at zero and clears enable. After a one-shot expiry with no new write, the control word reads 0x80 and there are no further expiries.
- R7: A prescaler select of s lets the count advance once every 2^s clock cycles (s from 0 to 7).
- R8: If enable is cleared by a write at edge D, the count still moves at edges D+1 and D+2 and then holds.
- R9: An expiry sets bit n of the pending register. Writing 1 to bit n of 0x04 clears it, and writing 0 leaves it unchanged.
- R10: `irq_o` is high exactly when some channel is both pending and unmasked. Bit n of 0x00 unmasks channel n.
- R11: The count is 64 bits wide and read as two 32-bit halves. An all-ones interval in periodic mode gives a free-running counter whose inverted low half rises by one per tick.
- R12: Channels are independent: a write or expiry on one channel changes no other channel's state or pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (8) | Register byte address |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Combinational read data for `addr_i` |
| irq_o | output | 1 | OR over channels of pending AND mask |

## Verification
The countdown is exercised in three ways:
- A short periodic interval checks when the first expiry lands relative to the control write, separately from the spacing of later expiries.
- A one-shot run checks that the count parks at zero and the enable bit clears, with no re-fire afterwards.
- An all-ones interval checks carry across the two halves and the inverted free-running count.

A prescaled run compares the count across a window of 16 cycles, so a wrong divide ratio shows up whatever phase the free-running divider starts in. The disable test reads the count right after the write and again later, which separates a two-cycle drain from an immediate stop or a stop that never comes. A masked one-shot on the second channel separates the pending flag from the interrupt line and shows that the first channel is not affected.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;

  localparam int SEL_W    = 3;
  localparam int CTRL_W   = 8;
  localparam int A_MASK   = 'h00;
  localparam int A_PEND   = 'h04;
  localparam int CH_FIRST = 'h10;
  localparam int CH_STEP  = 'h20;
  localparam int O_CTRL   = 'h0;
  localparam int O_IVL    = 'h4;
  localparam int O_IVH    = 'h8;
  localparam int O_CNTL   = 'hC;
  localparam int O_CNTH   = 'h10;

  typedef struct packed {
    logic             one_shot;
    logic [SEL_W-1:0] psel;
    logic [1:0]       zero_pad;
    logic             reload;
    logic             run_en;
  } ctrl_t;

  function automatic int chan_addr(input int n, input int off);
    return CH_FIRST + CH_STEP * n + off;
  endfunction

  function automatic ctrl_t ctrl_from_bus(input logic [CTRL_W-1:0] d);
    ctrl_t c;
    c          = ctrl_t'(d);
    c.zero_pad = '0;
    return c;
  endfunction

endpackage

// File: rtl/evtimer_prescaler.sv
module evtimer_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [(1<<SEL_W)-1:0] tick_o
);
  localparam int NT = 1 << SEL_W;
  localparam int PW = NT - 1;

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + PW'(1);
  end

  for (genvar s = 0; s < NT; s++) begin : g_tick
    if (s == 0) begin : g_every
      assign tick_o[s] = 1'b1;
    end else begin : g_div
      assign tick_o[s] = &div_q[s-1:0];
      // R7: a divided strobe never lasts two cycles
      assert_strobe_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[s] |=> !tick_o[s]);
    end
  end
endmodule

// File: rtl/evtimer_channel.sv
module evtimer_channel
  import evtimer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_we,
  input  logic                  ivl_we,
  input  logic                  ivh_we,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [(1<<SEL_W)-1:0] tick_vec,
  output ctrl_t                 ctrl_o,
  output logic [2*DATA_W-1:0]   ival_o,
  output logic [2*DATA_W-1:0]   cnt_o,
  output logic                  expire_o
);
  localparam int CNT_W = 2 * DATA_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] ival_q, cnt_q;
  logic             en_s1, en_s2;

  // named internal events
  logic tick_sel, run, at_zero, expire;
  assign tick_sel = tick_vec[ctrl_q.psel];
  assign run      = en_s2 & tick_sel;
  assign at_zero  = (cnt_q == '0);
  assign expire   = run & at_zero & ctrl_q.run_en & ~ctrl_q.reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1 <= 1'b0;
      en_s2 <= 1'b0;
    end else begin
      en_s1 <= ctrl_q.run_en;
      en_s2 <= en_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_from_bus(wdata[CTRL_W-1:0]);
    end else begin
      if (ctrl_q.reload) ctrl_q.reload <= 1'b0;
      if (expire && ctrl_q.one_shot) ctrl_q.run_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= '0;
    end else begin
      if (ivl_we) ival_q[DATA_W-1:0]     <= wdata;
      if (ivh_we) ival_q[CNT_W-1:DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ctrl_q.reload) begin
      cnt_q <= ival_q;
    end else if (run) begin
      if (!at_zero)                     cnt_q <= cnt_q - CNT_W'(1);
      else if (expire && !ctrl_q.one_shot) cnt_q <= ival_q;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign ival_o   = ival_q;
  assign cnt_o    = cnt_q;
  assign expire_o = expire;

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.reload |=> cnt_q == $past(ival_q));
  assert_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.reload && !ctrl_we |=> !ctrl_q.reload);
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run && !at_zero && !ctrl_q.reload |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_periodic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !ctrl_q.one_shot |=> cnt_q == $past(ival_q));
  assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ctrl_q.one_shot && !ctrl_we |=> !ctrl_q.run_en && cnt_q == '0);
  assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s2 && !ctrl_q.reload |=> $stable(cnt_q));
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
  import evtimer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int NT    = 1 << SEL_W;

  logic [NT-1:0]     tick_vec;
  logic [NUM_CH-1:0] mask_q, pend_q, expire_v, pend_clr;
  ctrl_t             ctrl_r [NUM_CH];
  logic [CNT_W-1:0]  ival_r [NUM_CH];
  logic [CNT_W-1:0]  cnt_r  [NUM_CH];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int n, input int off);
    return a == ADDR_W'(chan_addr(n, off));
  endfunction

  evtimer_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_vec)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    evtimer_channel #(.DATA_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (wr_en_i && hit(addr_i, n, O_CTRL)),
      .ivl_we   (wr_en_i && hit(addr_i, n, O_IVL)),
      .ivh_we   (wr_en_i && hit(addr_i, n, O_IVH)),
      .wdata    (wdata_i),
      .tick_vec (tick_vec),
      .ctrl_o   (ctrl_r[n]),
      .ival_o   (ival_r[n]),
      .cnt_o    (cnt_r[n]),
      .expire_o (expire_v[n])
    );

    assign pend_clr[n] = wr_en_i && (addr_i == ADDR_W'(A_PEND)) && wdata_i[n];

    assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      expire_v[n] |=> pend_q[n]);
    assert_pend_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_clr[n] && !expire_v[n] |=> !pend_q[n]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_W'(A_MASK)) mask_q <= wdata_i[NUM_CH-1:0];
      pend_q <= (pend_q & ~pend_clr) | expire_v;
    end
  end

  assign irq_o = |(pend_q & mask_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_MASK)) rdata_o[NUM_CH-1:0] = mask_q;
    if (addr_i == ADDR_W'(A_PEND)) rdata_o[NUM_CH-1:0] = pend_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (hit(addr_i, n, O_CTRL)) rdata_o[CTRL_W-1:0] = ctrl_r[n];
      if (hit(addr_i, n, O_IVL))  rdata_o = ival_r[n][DATA_W-1:0];
      if (hit(addr_i, n, O_IVH))  rdata_o = ival_r[n][CNT_W-1:DATA_W];
      if (hit(addr_i, n, O_CNTL)) rdata_o = cnt_r[n][DATA_W-1:0];
      if (hit(addr_i, n, O_CNTH)) rdata_o = cnt_r[n][CNT_W-1:DATA_W];
    end
  end

  assert_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
  assert_nopend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !irq_o);
endmodule

// File: tb/tb_evtimer_top.sv
`timescale 1ns/100ps
module tb_evtimer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0, cyc = 0;
  int exp_q[$];
  logic irq_prev = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evtimer_top dut (.clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
                   .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic wait_irq();
    while (!irq) step(1);
  endtask

  // scoreboard monitor: each rising edge of irq must match the next expected cycle
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (irq && !irq_prev) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R10: actual unexpected irq at %0d expected none", cyc);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != cyc) begin
            fails++;
            $display("FAIL R4/R5: actual irq at %0d expected %0d", cyc, e);
          end
        end
      end
      irq_prev = irq;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    int w, d;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(8'h00, v); chk("R1 mask", v, 0);
    rd(8'h04, v); chk("R1 pend", v, 0);
    rd(8'h10, v); chk("R1 ctrl0", v, 0);
    rd(8'h1C, v); chk("R1 cnt0", v, 0);
    rd(8'h30, v); chk("R1 ctrl1", v, 0);
    chk("R1 irq", irq, 0);

    // R4 R5 periodic, interval 5
    wr(8'h00, 32'h1);
    wr(8'h14, 32'd5);
    rd(8'h14, v); chk("R2 ival readback", v, 5);
    wr(8'h10, 32'h3);
    w = cyc;
    exp_q.push_back(w + 8);
    exp_q.push_back(w + 14);
    exp_q.push_back(w + 20);
    step(4);
    rd(8'h1C, v); chk("R4 count after W+4", v, 3);
    for (int k = 0; k < 3; k++) begin
      wait_irq();
      if (k == 2) wr(8'h10, 32'h0);
      wr(8'h04, 32'h1);
    end
    step(4);
    chk("R9 cleared irq", irq, 0);

    // R8 disable drain
    wr(8'h14, 32'd1000);
    wr(8'h10, 32'h3);
    step(10);
    wr(8'h10, 32'h0);
    d = cyc;
    rd(8'h1C, a);
    step(5);
    rd(8'h1C, b);
    chk("R8 two more steps", a - b, 2);

    // R3 R7 prescaler select 2
    wr(8'h10, 32'h23);
    rd(8'h10, v); chk("R3 reload visible", v, 32'h23);
    step(1);
    rd(8'h10, v); chk("R3 reload self-cleared", v, 32'h21);
    rd(8'h1C, v); chk("R3 interval loaded", v, 1000);
    step(5);
    rd(8'h1C, a);
    step(16);
    rd(8'h1C, b);
    chk("R7 four ticks in 16 cycles", a - b, 4);
    wr(8'h10, 32'h0);
    step(3);

    // R6 one-shot, interval 3
    wr(8'h14, 32'd3);
    wr(8'h10, 32'h83);
    w = cyc;
    exp_q.push_back(w + 6);
    step(8);
    rd(8'h10, v); chk("R6 enable dropped", v, 32'h80);
    rd(8'h1C, v); chk("R6 parked at zero", v, 0);
    chk("R10 irq pending", irq, 1);
    wr(8'h04, 32'h1);
    step(20);
    rd(8'h1C, v); chk("R6 still zero", v, 0);
    rd(8'h04, v); chk("R6 no re-fire", v, 0);

    // R9 R10 R12 masked one-shot on channel 1
    wr(8'h34, 32'd2);
    wr(8'h30, 32'h83);
    step(10);
    chk("R10 masked irq low", irq, 0);
    rd(8'h04, v); chk("R12 only ch1 pending", v, 32'h2);
    rd(8'h10, v); chk("R12 ch0 ctrl untouched", v, 32'h80);
    exp_q.push_back(cyc + 1);
    wr(8'h00, 32'h3);
    chk("R10 unmasked irq high", irq, 1);
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk("R9 write zero keeps", v, 32'h2);
    wr(8'h04, 32'h2);
    chk("R9 irq after clear", irq, 0);
    rd(8'h04, v); chk("R9 pend cleared", v, 0);

    // R11 free-running all-ones on channel 1
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h30, 32'h3);
    step(5);
    rd(8'h38, v); chk("R2 ival hi readback", v, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R11 count hi", v, 32'hFFFF_FFFF);
    rd(8'h3C, a);
    step(10);
    rd(8'h3C, b);
    chk("R11 inverted count rises", (~b) - (~a), 10);

    // R2 undefined addresses
    rd(8'h08, v); chk("R2 undefined 0x08", v, 0);
    rd(8'h0C, v); chk("R2 undefined 0x0C", v, 0);
    rd(8'h2C, v); chk("R2 undefined 0x2C", v, 0);
    rd(8'h70, v); chk("R2 undefined 0x70", v, 0);

    step(2);
    chk("R4 all expected expiries seen", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule